// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is a single-byte I2C target (slave) that sits on an open-drain SCL/SDA pair. Both lines are brought into the system clock domain through a short synchroniser. The edges of the synchronised lines then mark start and stop conditions and the bit clock. After a start, the block shifts in a 7-bit address and a direction bit. It acknowledges only when the address equals its configured address. In a write it then accepts one byte, and in a read it sends one byte.

The local side uses two simple interfaces. Received bytes appear on `rxData` with `rxValid`, and the local logic pulses `rxClear` once it has consumed the byte. For reads, the local logic presents `txData` and raises `txReady` when that byte is valid. When the local side cannot keep pace, the block holds SCL low. It does this when a read needs data that is not yet ready, and when a write would deliver a new byte before the previous one has been cleared. Because the bus is a wired AND, this pauses the master at its next clock.

The outputs `sclDriveLow` and `sdaDriveLow` drive the open-drain pull-downs. A value of 1 pulls the line low, and 0 releases it.

Top module: `i2c_stretch_target`

## Requirements
- R1: After reset both lines are released (`sclDriveLow`=0, `sdaDriveLow`=0) and `rxValid` is 0.
- R2: A falling SDA while SCL is high (start) restarts address reception from any state. A rising SDA while SCL is high (stop) returns the block to idle from any state. A byte cut short by either one is discarded and leaves `rxValid` unchanged.
- R3: When the 7 address bits, sent MSB first, equal `ownAddr`, the block pulls SDA low through the ninth (acknowledge) clock.
- R4: On an address mismatch the block gives no acknowledge. It drives neither line and captures nothing until the next start or stop.
- R5: When the direction bit is 0 (write), the block shifts in 8 data bits MSB first and acknowledges them. It then presents the byte on `rxData` with `rxValid`=1 and holds both until cleared.
- R6: A pulse on `rxClear` drops `rxValid` on the next clock.
- R7: If `rxValid` is still 1 when a write's data phase begins, the block holds SCL low until `rxValid` is cleared. If `rxValid` is 0, there is no stretch.
- R8: When the direction bit is 1 (read), the block puts `txData` on SDA MSB first. It changes its SDA drive only while the synchronised SCL is low.
- R9: If `txReady` is 0 when a read's data phase begins, the block holds SCL low until `txReady` rises. If `txReady` is already 1, there is no stretch.
- R10: After the master's acknowledge clock that follows the read byte, the block releases SDA. It drives nothing more until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ownAddr | input | 7 | Configured target address |
| sclIn | input | 1 | Sensed SCL bus level |
| sdaIn | input | 1 | Sensed SDA bus level |
| sclDriveLow | output | 1 | 1 pulls SCL low (stretch) |
| sdaDriveLow | output | 1 | 1 pulls SDA low |
| rxData | output | 8 | Last received write byte |
| rxValid | output | 1 | rxData holds an unconsumed byte |
| rxClear | input | 1 | Pulse: local side has taken rxData |
| txData | input | 8 | Byte to send on a read |
| txReady | input | 1 | txData is valid |

## Verification
A wrong control state appears on the bus within one SCL phase. A missing or extra acknowledge shows as the wrong level on the ninth clock. A wrongly entered or exited wait state shows as a stretch that is missing, too long, or endless, and the endless case is caught by the watchdog. A shift register that is out of step corrupts the byte seen on SDA or on `rxData` by the end of that same byte. A broken start or stop detector causes the next transaction to be refused or misframed. The bench compares every transfer against a behavioural master that honours stretching. On every clock it also checks that the target never moves SDA while SCL is high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_WAIT,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_WAIT,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_IGNORE
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;    // sample SDA into shift register
    logic loadTx;     // load txData, drive its MSB
    logic shiftOut;   // advance to next transmit bit
    logic captureRx;  // move shift register to rxData
    logic ackDrive;   // pull SDA low
    logic relSda;     // release SDA
  } dpCmd_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   startDet,
  input  logic   stopDet,
  input  logic   addrMatch,
  input  logic   rwBit,
  input  logic   rxValid,
  input  logic   txReady,
  output dpCmd_t cmd,
  output logic   sclLow
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST = CW'(DATA_W);

  tgtState_e st, stNext;
  logic [CW-1:0] cnt, cntNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNext;
      cnt <= cntNext;
    end
  end

  always_comb begin
    stNext  = st;
    cntNext = cnt;
    cmd     = '0;
    if (startDet) begin
      stNext = ST_ADDR; cntNext = '0; cmd.relSda = 1'b1;
    end else if (stopDet) begin
      stNext = ST_IDLE; cntNext = '0; cmd.relSda = 1'b1;
    end else begin
      case (st)
        ST_ADDR: begin
          if (sclRise) begin
            cmd.shiftIn = 1'b1; cntNext = cnt + 1'b1;
          end else if (sclFall && cnt == LAST) begin
            if (addrMatch) begin
              cmd.ackDrive = 1'b1; stNext = ST_ADDR_ACK;
            end else begin
              stNext = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          cmd.relSda = 1'b1; cntNext = '0;
          if (rwBit) begin
            if (txReady) begin cmd.loadTx = 1'b1; stNext = ST_RD_DATA; end
            else stNext = ST_RD_WAIT;
          end else begin
            stNext = rxValid ? ST_WR_WAIT : ST_WR_DATA;
          end
        end
        ST_WR_WAIT: if (!rxValid) stNext = ST_WR_DATA;
        ST_WR_DATA: begin
          if (sclRise) begin
            cmd.shiftIn = 1'b1; cntNext = cnt + 1'b1;
          end else if (sclFall && cnt == LAST) begin
            cmd.captureRx = 1'b1; cmd.ackDrive = 1'b1; stNext = ST_WR_ACK;
          end
        end
        ST_WR_ACK: if (sclFall) begin cmd.relSda = 1'b1; stNext = ST_IGNORE; end
        ST_RD_WAIT: if (txReady) begin cmd.loadTx = 1'b1; stNext = ST_RD_DATA; end
        ST_RD_DATA: begin
          if (sclRise) cntNext = cnt + 1'b1;
          else if (sclFall) begin
            if (cnt == LAST) begin cmd.relSda = 1'b1; stNext = ST_RD_ACK; end
            else cmd.shiftOut = 1'b1;
          end
        end
        ST_RD_ACK: if (sclFall) stNext = ST_IGNORE;
        default: ;
      endcase
    end
  end

  assign sclLow = (st == ST_WR_WAIT) || (st == ST_RD_WAIT);

  p_start_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (st == ST_ADDR && cnt == '0));
  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (st == ST_IDLE && !sclLow));
  p_rd_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_RD_WAIT && txReady && !startDet && !stopDet) |=> !sclLow);
  p_wr_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WR_WAIT && !rxValid && !startDet && !stopDet) |=> !sclLow);
endmodule

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              sdaS,
  input  logic [DATA_W-2:0] ownAddr,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxClear,
  output logic              addrMatch,
  output logic              rwBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              sdaLow
);
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdaLow   <= 1'b0;
    end else begin
      if (cmd.loadTx) begin
        shiftReg <= txData;
        sdaLow   <= ~txData[DATA_W-1];
      end else if (cmd.shiftOut) begin
        shiftReg <= shiftReg << 1;
        sdaLow   <= ~shiftReg[DATA_W-2];
      end else if (cmd.ackDrive) begin
        sdaLow   <= 1'b1;
      end else if (cmd.relSda) begin
        sdaLow   <= 1'b0;
      end
      if (cmd.shiftIn) shiftReg <= {shiftReg[DATA_W-2:0], sdaS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
    end else if (cmd.captureRx) begin
      rxData  <= shiftReg;
      rxValid <= 1'b1;
    end else if (rxClear) begin
      rxValid <= 1'b0;
    end
  end

  assign addrMatch = (shiftReg[DATA_W-1:1] == ownAddr);
  assign rwBit     = shiftReg[0];

  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !cmd.captureRx && !rxClear) |=> (rxValid && $stable(rxData)));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxClear && !cmd.captureRx) |=> !rxValid);
endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-2:0] ownAddr,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxClear,
  input  logic [DATA_W-1:0] txData,
  input  logic              txReady
);
  logic   sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic   addrMatch, rwBit;
  dpCmd_t cmd;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_tgt_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .addrMatch(addrMatch),
    .rwBit(rwBit), .rxValid(rxValid), .txReady(txReady),
    .cmd(cmd), .sclLow(sclDriveLow)
  );

  i2c_tgt_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaS(sdaS), .ownAddr(ownAddr),
    .txData(txData), .rxClear(rxClear), .addrMatch(addrMatch),
    .rwBit(rwBit), .rxData(rxData), .rxValid(rxValid), .sdaLow(sdaDriveLow)
  );

  p_sda_scl_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclS);
endmodule

// File: tb/i2c_stretch_target_tb_top.sv
`timescale 1ns/1ps
module i2c_stretch_target_tb_top;
  localparam int H = 20;  // half SCL period in system clocks
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterScl = 1'b1, masterSda = 1'b1;
  logic sclBus, sdaBus;
  logic sclDriveLow, sdaDriveLow, rxValid, rxClear, txReady;
  logic [7:0] rxData, txData;

  int tests = 0, fails = 0;
  int curStretch = 0;
  int sdaDrives = 0, sdaHighMoves = 0;
  bit watchSda = 0;

  always #2.5 clk = ~clk;

  assign sclBus = masterScl & ~sclDriveLow;
  assign sdaBus = masterSda & ~sdaDriveLow;

  i2c_stretch_target dut_i (
    .clk(clk), .rstN(rstN), .ownAddr(OWN), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .rxData(rxData), .rxValid(rxValid), .rxClear(rxClear),
    .txData(txData), .txReady(txReady)
  );

  // every-clock monitor: target SDA drive must not move while SCL is high
  logic prevScl = 1'b1, prevDrv = 1'b0;
  always @(negedge clk) begin
    if (rstN && prevScl && sclBus && (sdaDriveLow != prevDrv)) sdaHighMoves++;
    if (watchSda && sdaDriveLow) sdaDrives++;
    prevScl = sclBus;
    prevDrv = sdaDriveLow;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // raise SCL, wait out any stretch, sample SDA mid-high, lower SCL
  task automatic sclPulse(output logic s);
    int st = 0;
    masterScl = 1'b1;
    @(negedge clk);
    while (!sclBus) begin st++; @(negedge clk); end
    if (st > curStretch) curStretch = st;
    waitClk(H/2);
    s = sdaBus;
    waitClk(H/2);
    masterScl = 1'b0;
  endtask

  task automatic writeBit(input logic b);
    logic d;
    masterSda = b;
    waitClk(H);
    sclPulse(d);
  endtask

  task automatic readBit(output logic b);
    masterSda = 1'b1;
    waitClk(H);
    sclPulse(b);
  endtask

  task automatic startCond();
    logic d;
    masterSda = 1'b1;
    waitClk(H);
    masterScl = 1'b1;
    waitClk(H);
    masterSda = 1'b0;
    waitClk(H);
    masterScl = 1'b0;
    d = 1'b0;
  endtask

  task automatic stopCond();
    masterSda = 1'b0;
    waitClk(H);
    masterScl = 1'b1;
    waitClk(H);
    masterSda = 1'b1;
    waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    curStretch = 0;
    for (int i = 7; i >= 0; i--) writeBit(b[i]);
    readBit(ack);
  endtask

  task automatic recvByte(output logic [7:0] b, input logic nack);
    curStretch = 0;
    for (int i = 7; i >= 0; i--) readBit(b[i]);
    writeBit(nack);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic ackA, ackD, b;
    logic [7:0] got;
    rxClear = 1'b0; txReady = 1'b0; txData = 8'h00;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    // R1 reset state
    check(sclDriveLow == 0 && sdaDriveLow == 0, "R1 lines released", {sclDriveLow, sdaDriveLow}, 0);
    check(rxValid == 0, "R1 rxValid clear", rxValid, 0);

    // R3/R5/R7: plain write
    startCond();
    sendByte({OWN, 1'b0}, ackA);
    check(ackA == 0, "R3 own address acked", ackA, 0);
    sendByte(8'hC3, ackD);
    check(ackD == 0, "R5 data acked", ackD, 0);
    check(curStretch == 0, "R7 no stretch when empty", curStretch, 0);
    stopCond();
    check(rxValid == 1 && rxData == 8'hC3, "R5 byte captured", rxData, 8'hC3);

    // R7: second write while byte pending -> stretch until cleared
    startCond();
    sendByte({OWN, 1'b0}, ackA);
    fork
      sendByte(8'h3C, ackD);
      begin
        waitClk(300);
        check(rxData == 8'hC3 && rxValid, "R5 byte held while pending", rxData, 8'hC3);
        check(sclBus == 0, "R7 SCL held low while pending", sclBus, 0);
        rxClear = 1'b1; waitClk(1); rxClear = 1'b0;
      end
    join
    check(curStretch >= 200, "R7 stretch length", curStretch, 200);
    check(ackD == 0, "R5 second byte acked", ackD, 0);
    stopCond();
    check(rxValid == 1 && rxData == 8'h3C, "R5 second byte captured", rxData, 8'h3C);

    // R6: clear
    rxClear = 1'b1; waitClk(1); rxClear = 1'b0; waitClk(1);
    check(rxValid == 0, "R6 rxClear drops rxValid", rxValid, 0);

    // R4: mismatched address is ignored
    watchSda = 1;
    startCond();
    sendByte({7'h11, 1'b0}, ackA);
    sendByte(8'hFF, ackD);
    stopCond();
    watchSda = 0;
    check(ackA == 1, "R4 no address ack", ackA, 1);
    check(ackD == 1, "R4 no data ack", ackD, 1);
    check(rxValid == 0, "R4 nothing captured", rxValid, 0);
    check(sdaDrives == 0, "R4 SDA never driven", sdaDrives, 0);

    // R8/R9/R10: read with data ready
    txData = 8'hA5; txReady = 1'b1;
    startCond();
    sendByte({OWN, 1'b1}, ackA);
    check(ackA == 0, "R3 read address acked", ackA, 0);
    recvByte(got, 1'b1);
    check(got == 8'hA5, "R8 read byte", got, 8'hA5);
    check(curStretch == 0, "R9 no stretch when ready", curStretch, 0);
    check(sdaDriveLow == 0, "R10 SDA released after nack", sdaDriveLow, 0);
    stopCond();

    // R9: read with data late
    txReady = 1'b0; txData = 8'h00;
    startCond();
    sendByte({OWN, 1'b1}, ackA);
    fork
      recvByte(got, 1'b0);
      begin
        waitClk(400);
        txData = 8'h6E; txReady = 1'b1;
      end
    join
    check(curStretch >= 300, "R9 stretch until ready", curStretch, 300);
    check(got == 8'h6E, "R8 late read byte", got, 8'h6E);
    readBit(b);
    check(b == 1, "R10 no further byte after ack", b, 1);
    stopCond();
    txReady = 1'b0;

    // R2: stop in the middle of a write byte
    startCond();
    sendByte({OWN, 1'b0}, ackA);
    writeBit(1'b1); writeBit(1'b0);
    stopCond();
    waitClk(5);
    check(rxValid == 0, "R2 aborted byte discarded", rxValid, 0);
    check(sdaDriveLow == 0 && sclDriveLow == 0, "R2 stop releases", {sclDriveLow, sdaDriveLow}, 0);

    // R2: repeated start in the middle of an address
    startCond();
    writeBit(1'b0); writeBit(1'b1); writeBit(1'b1);
    startCond();
    sendByte({OWN, 1'b0}, ackA);
    check(ackA == 0, "R2 restart reframes address", ackA, 0);
    sendByte(8'h81, ackD);
    stopCond();
    check(rxValid == 1 && rxData == 8'h81, "R2 byte after restart", rxData, 8'h81);

    check(sdaHighMoves == 0, "R8 SDA drive stable while SCL high", sdaHighMoves, 0);
    summary();
    $finish;
  end
endmodule